// File: doc/BRIEF.md
# Serial Character Transmitter with Address Tagging

This block turns characters written into a one-entry holding register into asynchronous serial frames on a single output line. A line control word, written and read through a simple register port, selects the number of data bits (five to eight), the parity mode (none, odd, even, or a fixed value), one or two stop bits, a break condition that forces the line low, and a nine-bit mode. In nine-bit mode every character carries one extra tag bit that marks it as an address or as data.

The bit rate comes from outside. The `bit_tick` input pulses for one clock per bit period, and the line changes only on those cycles. The line control word is read when a character starts and is copied into the shift path at that moment. A control write made while a character is on the line therefore affects only the characters that follow. The address-tag flag clears itself on every accepted character write, so software sets it once for each address character.

Top module: `uart9_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1 and the control register reads 0.
- R2: Address 1 is the control register. Write data bits 9:0 are stored, and a read returns them with bits 31:10 as zero. The field order from bit 9 down to bit 0 is: nine-bit enable, address flag, fixed parity, word length (2 bits), FIFO enable (stored only), two stop bits, even select, parity enable, break.
- R3: The word-length field selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper bits of the written character are not sent.
- R4: A frame is a 0 start bit, then the data bits with the least significant bit first, then the optional parity or tag bit, then one stop bit of 1. Setting the stop-count bit gives two stop bits. Each bit lasts one `bit_tick` period.
- R5: With parity enabled and fixed parity off, the parity bit makes the count of ones in the data bits plus the parity bit even when even select is 1, and odd when even select is 0.
- R6: With parity enabled and fixed parity on, the parity bit is 0 when even select is 1 and 1 when even select is 0.
- R7: In nine-bit mode, one tag bit follows the data bits and no parity bit is sent. The tag is 1 if the address flag was set when the character was written, and 0 otherwise.
- R8: Every accepted write to the data register (address 0) clears the address flag. A read of the control register shows the flag as 0 afterwards.
- R9: With nine-bit mode off, the address flag has no effect on the frame and no tag bit is sent.
- R10: A control write made while a character is being sent does not change that character. The new settings apply from the next character.
- R11: While break is set and no character is on the line, `txd` is held at 0. A character already in progress finishes first. Normal idle level returns once break is cleared.
- R12: `tx_ready` is 0 while the holding register has an unsent character. A data write made while `tx_ready` is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 = data, 1 = control |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 = held character, 1 = control |
| rd_data | output | 32 | Combinational read data |
| tx_ready | output | 1 | Holding register empty |
| txd | output | 1 | Serial output line, idle high |

## Verification
The assertions assume that `bit_tick` pulses are at least a few clocks apart. They also assume that register writes are single-cycle strobes whose address field is 0 or 1. The bench produces ticks every six clocks, and it starts each write just after a tick. As a result, no write ever shares a cycle with a character start. The bench also changes the control word only while `tx_ready` is 1. This is required because the expected frame is computed when the character is written. Keeping control writes to those moments makes that computed frame match the settings the block actually uses when the character starts.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int DATA_W   = 8;
  localparam int MIN_DATA = 5;
  localparam int CTRL_W   = 10;
  localparam int FRAME_W  = DATA_W + 3;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  typedef struct packed {
    logic       nine_en;
    logic       addr_tx;
    logic       stick;
    logic [1:0] wlen;
    logic       fifo_en;
    logic       two_stop;
    logic       even;
    logic       par_en;
    logic       brk;
  } lcr_t;
endpackage

// File: rtl/uart9_rst_sync.sv
module uart9_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/uart9_regs.sv
module uart9_regs
  import uart9_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              pop,
  output lcr_t              lcr,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_tag
);
  lcr_t              lcr_q, lcr_d;
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              tag_q, tag_d;
  logic              data_acc, ctrl_wr;
  logic              unused_wr;

  assign unused_wr = ^wr_data[REG_W-1:CTRL_W];
  assign data_acc  = wr_en && (wr_addr == ADDR_DATA) && !full_q;
  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);

  always_comb begin
    lcr_d  = lcr_q;
    full_d = full_q;
    data_d = data_q;
    tag_d  = tag_q;
    if (ctrl_wr) begin
      lcr_d = lcr_t'(wr_data[CTRL_W-1:0]);
    end else if (data_acc) begin
      lcr_d.addr_tx = 1'b0;
    end
    if (data_acc) begin
      full_d = 1'b1;
      data_d = wr_data[DATA_W-1:0];
      tag_d  = lcr_q.nine_en & lcr_q.addr_tx;
    end else if (pop) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      full_q <= 1'b0;
      data_q <= '0;
      tag_q  <= 1'b0;
    end else begin
      lcr_q  <= lcr_d;
      full_q <= full_d;
      data_q <= data_d;
      tag_q  <= tag_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CTRL) rd_data[CTRL_W-1:0] = lcr_q;
    else                      rd_data[DATA_W-1:0] = data_q;
  end

  assign lcr       = lcr_q;
  assign hold_full = full_q;
  assign hold_data = data_q;
  assign hold_tag  = tag_q;

  // R8: an accepted character write leaves the address flag clear
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_DATA && !full_q) |=> !lcr_q.addr_tx);

  // R12: an unsent character stays put until the shifter takes it
  assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !pop) |=> (full_q && $stable(data_q)));
endmodule

// File: rtl/uart9_frame_build.sv
module uart9_frame_build
  import uart9_pkg::*;
(
  input  lcr_t               lcr,
  input  logic [DATA_W-1:0]  data,
  input  logic               tag,
  output logic [FRAME_W-1:0] rest_bits,
  output logic [CNT_W-1:0]   rest_len
);
  int   ndata;
  logic par_x, par_bit, has_extra, extra;
  logic unused_lcr;

  assign unused_lcr = lcr.fifo_en ^ lcr.addr_tx ^ lcr.brk;

  always_comb begin
    ndata = MIN_DATA + int'(lcr.wlen);
    par_x = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < ndata) par_x = par_x ^ data[i];
    end
    if (lcr.stick)     par_bit = ~lcr.even;
    else if (lcr.even) par_bit = par_x;
    else               par_bit = ~par_x;
    has_extra = lcr.nine_en | lcr.par_en;
    extra     = lcr.nine_en ? tag : par_bit;

    rest_bits = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < ndata) rest_bits[i] = data[i];
    end
    if (has_extra) rest_bits[ndata] = extra;
    rest_len = CNT_W'(ndata + int'(has_extra) + 1 + int'(lcr.two_stop));
  end
endmodule

// File: rtl/uart9_shifter.sv
module uart9_shifter
  import uart9_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               brk,
  input  logic               hold_full,
  input  logic [FRAME_W-1:0] rest_bits,
  input  logic [CNT_W-1:0]   rest_len,
  output logic               pop,
  output logic               txd
);
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               txd_q, txd_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    txd_d = txd_q;
    pop   = 1'b0;
    if (tick) begin
      if (cnt_q != '0) begin
        txd_d = sh_q[0];
        sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
        cnt_d = cnt_q - 1'b1;
      end else if (brk) begin
        txd_d = 1'b0;
      end else if (hold_full) begin
        pop   = 1'b1;
        txd_d = 1'b0;
        sh_d  = rest_bits;
        cnt_d = rest_len;
      end else begin
        txd_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
      txd_q <= 1'b1;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      txd_q <= txd_d;
    end
  end

  assign txd = txd_q;

  // R4: the remaining-bit count never exceeds the longest frame
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W));

  // R11: a boundary tick with break set drives the line low
  assert_break_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && brk) |=> !txd_q);
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_addr,
  output logic [31:0] rd_data,
  output logic        tx_ready,
  output logic        txd
);
  logic               rst_sync_n;
  lcr_t               lcr;
  logic               hold_full, hold_tag, pop;
  logic [DATA_W-1:0]  hold_data;
  logic [FRAME_W-1:0] rest_bits;
  logic [CNT_W-1:0]   rest_len;

  uart9_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  uart9_regs #(.REG_W(32)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pop(pop),
    .lcr(lcr), .hold_full(hold_full), .hold_data(hold_data), .hold_tag(hold_tag)
  );

  uart9_frame_build u_build (
    .lcr(lcr), .data(hold_data), .tag(hold_tag),
    .rest_bits(rest_bits), .rest_len(rest_len)
  );

  uart9_shifter u_shift (
    .clk(clk), .rst_n(rst_sync_n), .tick(bit_tick), .brk(lcr.brk),
    .hold_full(hold_full), .rest_bits(rest_bits), .rest_len(rest_len),
    .pop(pop), .txd(txd)
  );

  assign tx_ready = !hold_full;

  // R12: an accepted character write makes the block not ready
  assert_ready_drop_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == ADDR_DATA && tx_ready) |=> !tx_ready);

  // R4: taking a character puts the start bit on the line
  assert_start_bit_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pop |=> !txd);
endmodule

// File: tb/uart9_tx_tb_top.sv
module uart9_tx_tb_top;
  localparam int DIV = 6;

  typedef struct {
    logic [15:0] bits;
    int          len;
    string       req;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_tick;
  logic        wr_en;
  logic        wr_addr;
  logic [31:0] wr_data;
  logic        rd_addr;
  logic [31:0] rd_data;
  logic        tx_ready;
  logic        txd;

  int          vec_cnt = 0;
  int          miss_cnt = 0;
  int          tick_div = 0;
  frame_t      exp_q[$];
  frame_t      cur_exp;
  logic [15:0] cur_bits;
  int          pos = 0;
  bit          in_frame = 0;
  bit          brk_expected = 0;
  bit          done = 0;
  logic [9:0]  m_lcr = '0;

  always #4 clk = ~clk;

  uart9_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_ready(tx_ready), .txd(txd)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      miss_cnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic frame_t mk_frame(logic [7:0] d, logic [9:0] c, logic tag, string req);
    frame_t f;
    int n, k;
    logic p;
    n = 5 + int'(c[6:5]);
    f.bits = '1;
    f.bits[0] = 1'b0;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      f.bits[1+i] = d[i];
      p = p ^ d[i];
    end
    k = 1 + n;
    if (c[9]) begin
      f.bits[k] = tag;
      k++;
    end else if (c[1]) begin
      f.bits[k] = c[7] ? ~c[2] : (c[2] ? p : ~p);
      k++;
    end
    f.len = k + 1 + int'(c[3]);
    f.req = req;
    return f;
  endfunction

  // tick generator and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      bit_tick = 1'b0;
      tick_div = 0;
      in_frame = 0;
    end else begin
      if (bit_tick) begin
        if (in_frame) begin
          cur_bits[pos] = txd;
          pos++;
          if (pos == cur_exp.len) begin
            in_frame = 0;
            chk(cur_exp.req, 32'(cur_bits) & ((32'd1 << pos) - 1),
                32'(cur_exp.bits) & ((32'd1 << pos) - 1));
          end
        end else if (txd == 1'b0) begin
          if (exp_q.size() > 0) begin
            cur_exp  = exp_q.pop_front();
            cur_bits = '1;
            cur_bits[0] = 1'b0;
            pos = 1;
            in_frame = 1;
          end else if (!brk_expected) begin
            chk("R12 unexpected frame", 32'd1, 32'd0);
          end
        end
      end
      tick_div = (tick_div == DIV - 1) ? 0 : tick_div + 1;
      bit_tick = (tick_div == 0);
    end
  end

  task automatic sync_after_tick();
    do begin
      @(negedge clk); #1;
    end while (tick_div != 1);
  endtask

  task automatic do_write(logic a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic set_ctrl(logic [9:0] c);
    sync_after_tick();
    do_write(1'b1, 32'(c));
    m_lcr = c;
  endtask

  task automatic send_char(logic [7:0] d, string req);
    do begin
      @(negedge clk); #1;
    end while (!(tx_ready && tick_div == 1));
    exp_q.push_back(mk_frame(d, m_lcr, m_lcr[9] & m_lcr[8], req));
    do_write(1'b0, 32'hABCD_0000 | 32'(d));
    m_lcr[8] = 1'b0;
  endtask

  task automatic drain();
    do begin
      @(negedge clk); #1;
    end while (exp_q.size() != 0 || in_frame || !tx_ready);
    repeat (2 * DIV) @(negedge clk);
    #1;
  endtask

  task automatic read_chk(logic a, logic [31:0] exp, string req);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miss_cnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 txd", 32'(txd), 32'd1);
    chk("R1 tx_ready", 32'(tx_ready), 32'd1);
    read_chk(1'b1, 32'd0, "R1 ctrl read");

    // R2 reserved bits dropped, stored fields read back
    set_ctrl(10'h000);
    sync_after_tick();
    do_write(1'b1, 32'hFFFF_FDEA);
    m_lcr = 10'h1EA;
    read_chk(1'b1, 32'h0000_01EA, "R2 ctrl readback");
    // R9: address flag set but nine-bit mode off: no tag, 8 bits, fixed parity
    send_char(8'hC3, "R9 flag ignored");
    drain();
    read_chk(1'b1, 32'h0000_00EA, "R8 flag cleared without nine-bit");

    // R3 word lengths, R4 framing, R5 parity
    set_ctrl(10'h060);
    send_char(8'hA5, "R4 8N1");
    send_char(8'h3C, "R4 8N1 back to back");
    drain();
    set_ctrl(10'h000);
    send_char(8'hFF, "R3 5 bits");
    drain();
    set_ctrl(10'h022);
    send_char(8'hD6, "R5 6 bits odd");
    drain();
    set_ctrl(10'h046);
    send_char(8'h2B, "R5 7 bits even");
    drain();
    set_ctrl(10'h068);
    send_char(8'h81, "R4 two stop bits");
    drain();

    // R6 fixed parity
    set_ctrl(10'h0E2);
    send_char(8'h00, "R6 fixed one");
    drain();
    set_ctrl(10'h0E6);
    send_char(8'hFE, "R6 fixed zero");
    drain();

    // R7 nine-bit tags, R8 self-clear
    set_ctrl(10'h360);
    send_char(8'h81, "R7 address tag");
    send_char(8'h55, "R7 data tag");
    drain();
    read_chk(1'b1, 32'h0000_0260, "R8 flag cleared");
    set_ctrl(10'h262);
    send_char(8'h0F, "R7 no parity in nine-bit");
    drain();

    // R10 control change held back until character boundary
    set_ctrl(10'h060);
    send_char(8'h96, "R10 old settings");
    do begin @(negedge clk); #1; end while (!tx_ready || !in_frame);
    set_ctrl(10'h00E);
    send_char(8'h1B, "R10 new settings");
    drain();

    // R12 write while full is dropped
    set_ctrl(10'h060);
    sync_after_tick();
    exp_q.push_back(mk_frame(8'h5A, m_lcr, 1'b0, "R12 first kept"));
    do_write(1'b0, 32'h0000_005A);
    chk("R12 not ready", 32'(tx_ready), 32'd0);
    do_write(1'b0, 32'h0000_00E7);
    read_chk(1'b0, 32'h0000_005A, "R12 held character unchanged");
    drain();

    // R11 break after the current character
    send_char(8'hC6, "R11 char before break");
    do begin @(negedge clk); #1; end while (!tx_ready || !in_frame);
    brk_expected = 1;
    set_ctrl(10'h061);
    drain();
    repeat (3 * DIV) @(negedge clk);
    #1;
    chk("R11 line held low", 32'(txd), 32'd0);
    set_ctrl(10'h060);
    repeat (3 * DIV) @(negedge clk);
    #1;
    chk("R11 idle after break", 32'(txd), 32'd1);
    brk_expected = 0;
    send_char(8'h3A, "R11 framing resumes");
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end
endmodule